// File: doc/BRIEF.md
# Serially Loaded Output Freeze Control

This block holds a 12-bit word that decides which clock outputs of a multi-bank clock distributor run and which are held low. The word arrives over a two-wire serial link: a free-running serial clock and a data line that rests high. A frame opens with one low start bit. Twelve data bits follow, one per serial clock period, and each is sampled on the rising edge. The receiver waits for a start bit, gathers the twelve bits, and writes all of them to the register on the same edge.

Every register bit gates one ungated clock in that clock's own domain. The bit crosses into the domain through a two-stage synchronizer clocked on the falling edge. The gate therefore changes state only while its clock is low, and an output never shows a shortened or partial high pulse when it stops or starts. Bank C output 0 and the feedback clock have no bit, so they always run. The block does not generate any clock. It takes the ungated clocks and passes them on, gated or not.

Top module: `out_freeze_ctl`

## Requirements
- R1: While the receiver is idle, a high level on `sdata_i` at a rising `sclk_i` edge leaves it idle and leaves `enable_word_o` unchanged.
- R2: A low level sampled while idle is a start bit. The next 12 rising edges sample data bits D0 (first) to D11 (last). `enable_word_o` takes all 12 bits on the edge that samples D11, with bit k = Dk. The receiver is idle again on that same edge, so a start bit may follow at once.
- R3: Word bits 0..3 gate `q_a_o[0..3]`, bits 4..7 gate `q_b_o[0..3]`, bits 8..10 gate `q_c_o[1..3]`, and bit 11 gates `sync_o`.
- R4: A bit value of 1 makes the output follow its ungated clock. A value of 0 freezes the output.
- R5: A frozen output stays at logic 0, and no gated output is ever high while its ungated clock is low.
- R6: `q_c_o[0]` always equals `clk_c_i[0]` and `fb_o` always equals `clk_fb_i`, whatever the word holds.
- R7: Freezing and releasing never produce a partial pulse. Every edge of a gated output falls at the same instant as an edge of its ungated clock. A new bit value takes effect within two falling edges of that clock.
- R8: `rst_n` low, applied asynchronously, sets `enable_word_o` to all ones, returns the receiver to idle (this includes a frame cut off partway) and enables every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Free-running serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data line, high when idle |
| clk_a_i | input | 4 | Ungated bank A clocks |
| clk_b_i | input | 4 | Ungated bank B clocks |
| clk_c_i | input | 4 | Ungated bank C clocks |
| clk_sync_i | input | 1 | Ungated sync clock |
| clk_fb_i | input | 1 | Ungated feedback clock |
| q_a_o | output | 4 | Gated bank A clocks |
| q_b_o | output | 4 | Gated bank B clocks |
| q_c_o | output | 4 | Bank C clocks, index 0 ungated |
| sync_o | output | 1 | Gated sync clock |
| fb_o | output | 1 | Feedback clock, always running |
| enable_word_o | output | 12 | Current freeze/enable register |

## Verification
Six words are loaded while all fourteen clocks run at different periods. The set includes all ones, all zeros, two complementary alternating patterns, and two words that differ from their neighbours in only the end bits. Together they show whether each bit reaches its own output and no other, and whether bit order and the bank boundaries are correct. A sampling monitor runs throughout and looks for any output edge that does not coincide with a source edge, so every freeze and release in the sequence is tested for partial pulses. Directed cases add a long idle stretch, two frames sent back to back, and a reset that cuts a frame short.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int BANK_A_N = 4;
  localparam int BANK_B_N = 4;
  localparam int BANK_C_N = 4;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_DATA = 1'b1
  } rx_state_e;
endpackage

// File: rtl/frz_rst_sync.sv
module frz_rst_sync (
  input  logic clk_i,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/frz_rx.sv
module frz_rx
  import frz_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              sclk_i,
  input  logic              srst_n,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_IX = CNT_W'(WORD_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q;
  logic              sh_en, word_en;

  // next state: first bit enters at the top and ends up at index 0
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_en   = 1'b0;
    word_en = 1'b0;
    sh_d    = {sdata_i, sh_q[WORD_W-1:1]};
    case (state_q)
      RX_HUNT: begin
        if (!sdata_i) begin
          state_d = RX_DATA;
          cnt_d   = '0;
        end
      end
      RX_DATA: begin
        sh_en = 1'b1;
        if (cnt_q == LAST_IX) begin
          word_en = 1'b1;
          state_d = RX_HUNT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = RX_HUNT;
    endcase
  end

  always_ff @(posedge sclk_i or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      sh_q    <= '1;
      word_q  <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (sh_en)   sh_q   <= sh_d;
      if (word_en) word_q <= sh_d;
    end
  end

  assign word_o = word_q;
  assign busy_o = (state_q == RX_DATA);
endmodule

// File: rtl/frz_gate.sv
module frz_gate (
  input  logic clk_src_i,
  input  logic rst_n,
  input  logic en_i,
  output logic clk_o
);
  logic en_m_q;
  logic en_s_q;

  // both stages move on the falling edge, so the gate only changes while the clock is low
  always_ff @(negedge clk_src_i or negedge rst_n) begin
    if (!rst_n) begin
      en_m_q <= 1'b1;
      en_s_q <= 1'b1;
    end else begin
      en_m_q <= en_i;
      en_s_q <= en_m_q;
    end
  end

  assign clk_o = clk_src_i & en_s_q;
endmodule

// File: rtl/out_freeze_ctl.sv
module out_freeze_ctl
  import frz_pkg::*;
#(
  parameter int A_N = BANK_A_N,
  parameter int B_N = BANK_B_N,
  parameter int C_N = BANK_C_N
) (
  input  logic                       sclk_i,
  input  logic                       rst_n,
  input  logic                       sdata_i,
  input  logic [A_N-1:0]             clk_a_i,
  input  logic [B_N-1:0]             clk_b_i,
  input  logic [C_N-1:0]             clk_c_i,
  input  logic                       clk_sync_i,
  input  logic                       clk_fb_i,
  output logic [A_N-1:0]             q_a_o,
  output logic [B_N-1:0]             q_b_o,
  output logic [C_N-1:0]             q_c_o,
  output logic                       sync_o,
  output logic                       fb_o,
  output logic [A_N+B_N+C_N-1:0]     enable_word_o
);
  localparam int WORD_W  = A_N + B_N + C_N;
  localparam int B_LO    = A_N;
  localparam int C_LO    = A_N + B_N;
  localparam int SYNC_IX = WORD_W - 1;

  logic              srst_n;
  logic              rx_busy;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] src_vec;
  logic [WORD_W-1:0] gated;

  frz_rst_sync u_rst (
    .clk_i  (sclk_i),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  frz_rx #(.WORD_W(WORD_W)) u_rx (
    .sclk_i  (sclk_i),
    .srst_n  (srst_n),
    .sdata_i (sdata_i),
    .word_o  (word),
    .busy_o  (rx_busy)
  );

  // bit k of the word gates src_vec[k]
  assign src_vec = {clk_sync_i, clk_c_i[C_N-1:1], clk_b_i, clk_a_i};

  for (genvar k = 0; k < WORD_W; k++) begin : g_gate
    frz_gate u_gate (
      .clk_src_i (src_vec[k]),
      .rst_n     (rst_n),
      .en_i      (word[k]),
      .clk_o     (gated[k])
    );
  end

  assign q_a_o         = gated[A_N-1:0];
  assign q_b_o         = gated[C_LO-1:B_LO];
  assign q_c_o         = {gated[SYNC_IX-1:C_LO], clk_c_i[0]};
  assign sync_o        = gated[SYNC_IX];
  assign fb_o          = clk_fb_i;
  assign enable_word_o = word;
endmodule

// File: rtl/out_freeze_chk.sv
module out_freeze_chk #(
  parameter int A_N = 4,
  parameter int B_N = 4,
  parameter int C_N = 4
) (
  input logic                   sclk_i,
  input logic                   rst_n,
  input logic                   sdata_i,
  input logic                   rx_busy,
  input logic [A_N+B_N+C_N-1:0] enable_word_o,
  input logic [A_N-1:0]         clk_a_i,
  input logic [B_N-1:0]         clk_b_i,
  input logic [C_N-1:0]         clk_c_i,
  input logic                   clk_sync_i,
  input logic                   clk_fb_i,
  input logic [A_N-1:0]         q_a_o,
  input logic [B_N-1:0]         q_b_o,
  input logic [C_N-1:0]         q_c_o,
  input logic                   sync_o,
  input logic                   fb_o
);
  a_r1_hunt_idle: assert property (@(posedge sclk_i) disable iff (!rst_n)
    (!rx_busy && sdata_i) |=> !rx_busy);

  a_r2_commit_in_frame: assert property (@(posedge sclk_i) disable iff (!rst_n)
    (enable_word_o != $past(enable_word_o)) |-> $past(rx_busy));

  a_r5_never_high_when_low: assert property (@(negedge sclk_i) disable iff (!rst_n)
    ((q_a_o & ~clk_a_i) == '0) && ((q_b_o & ~clk_b_i) == '0) &&
    ((q_c_o & ~clk_c_i) == '0) && !(sync_o && !clk_sync_i));

  a_r6_fixed_follow: assert property (@(negedge sclk_i) disable iff (!rst_n)
    (fb_o == clk_fb_i) && (q_c_o[0] == clk_c_i[0]));
endmodule

bind out_freeze_ctl out_freeze_chk #(.A_N(A_N), .B_N(B_N), .C_N(C_N)) u_chk (
  .sclk_i        (sclk_i),
  .rst_n         (rst_n),
  .sdata_i       (sdata_i),
  .rx_busy       (rx_busy),
  .enable_word_o (enable_word_o),
  .clk_a_i       (clk_a_i),
  .clk_b_i       (clk_b_i),
  .clk_c_i       (clk_c_i),
  .clk_sync_i    (clk_sync_i),
  .clk_fb_i      (clk_fb_i),
  .q_a_o         (q_a_o),
  .q_b_o         (q_b_o),
  .q_c_o         (q_c_o),
  .sync_o        (sync_o),
  .fb_o          (fb_o)
);

// File: tb/out_freeze_ctl_test.sv
`timescale 1ns/100ps
module out_freeze_ctl_test;
  localparam int NSRC = 14;
  localparam int NV   = 6;
  localparam logic [11:0] VECS [0:NV-1] = '{12'hFFF, 12'h000, 12'hA5A, 12'h5A5, 12'h801, 12'h7FE};

  logic sclk, rst_n, sdata;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] q;
  logic [3:0] q_a, q_b, q_c;
  logic sync_o, fb_o;
  logic [11:0] word;
  int n_chk, n_bad;
  int src_rise [NSRC];
  int q_rise   [NSRC];
  int q_high   [NSRC];
  int runts;

  out_freeze_ctl uut (
    .sclk_i(sclk), .rst_n(rst_n), .sdata_i(sdata),
    .clk_a_i(src[3:0]), .clk_b_i(src[7:4]), .clk_c_i(src[11:8]),
    .clk_sync_i(src[12]), .clk_fb_i(src[13]),
    .q_a_o(q_a), .q_b_o(q_b), .q_c_o(q_c), .sync_o(sync_o), .fb_o(fb_o),
    .enable_word_o(word)
  );

  assign q = {fb_o, sync_o, q_c, q_b, q_a};

  initial begin sclk = 1'b0; forever #4 sclk = ~sclk; end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    initial begin
      src[g] = 1'b0;
      forever #(3 + g) src[g] = ~src[g];
    end
  end

  // sampling monitor: every gated edge must coincide with a source edge (R7)
  initial begin
    logic [NSRC-1:0] ps, pq;
    runts = 0;
    #0.25;
    ps = src; pq = q;
    forever begin
      #0.5;
      for (int i = 0; i < NSRC; i++) begin
        if (src[i] && !ps[i]) src_rise[i]++;
        if (q[i] && !pq[i]) q_rise[i]++;
        if (q[i]) q_high[i]++;
        if (q[i] != pq[i] && src[i] == ps[i]) runts++;
      end
      ps = src; pq = q;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NSRC; i++) begin
      src_rise[i] = 0; q_rise[i] = 0; q_high[i] = 0;
    end
  endtask

  task automatic send_frame(input logic [11:0] w);
    @(negedge sclk); sdata = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge sclk); sdata = w[k];
    end
  endtask

  task automatic idle_bits(input int n);
    repeat (n) begin @(negedge sclk); sdata = 1'b1; end
  endtask

  function automatic bit exp_en(input logic [11:0] w, input int i);
    if (i < 8) return w[i];
    if (i == 8 || i == 13) return 1'b1;
    if (i < 12) return w[i-1];
    return w[11];
  endfunction

  task automatic measure(input logic [11:0] w);
    #100;
    clear_counts();
    #300;
    for (int i = 0; i < NSRC; i++) begin
      if (i == 8 || i == 13)
        check(q_rise[i] == src_rise[i] && src_rise[i] > 0, "R6 fixed output", q_rise[i], src_rise[i]);
      else if (exp_en(w, i))
        check(q_rise[i] == src_rise[i] && src_rise[i] > 0, "R3 R4 enabled output", q_rise[i], src_rise[i]);
      else
        check(q_rise[i] == 0 && q_high[i] == 0, "R3 R5 frozen output", q_high[i], 0);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    sdata = 1'b1; rst_n = 1'b0;
    clear_counts();
    #20;
    check(word == 12'hFFF, "R8 reset word", word, 12'hFFF);
    rst_n = 1'b1;
    idle_bits(4);
    measure(12'hFFF);

    // R1: long idle leaves the word alone
    idle_bits(40);
    check(word == 12'hFFF, "R1 idle hunt", word, 12'hFFF);

    // main table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      runts = 0;
      send_frame(VECS[v]);
      @(posedge sclk); #1;
      check(word == VECS[v], "R2 committed word", word, VECS[v]);
      idle_bits(2);
      measure(VECS[v]);
      check(runts == 0, "R7 no partial pulse", runts, 0);
    end

    // R2: back-to-back frames without an idle bit
    send_frame(12'h123);
    @(posedge sclk); #1;
    check(word == 12'h123, "R2 first of pair", word, 12'h123);
    send_frame(12'hC3C);
    @(posedge sclk); #1;
    check(word == 12'hC3C, "R2 second of pair", word, 12'hC3C);
    idle_bits(2);
    measure(12'hC3C);

    // R8: reset cuts a frame short
    @(negedge sclk); sdata = 1'b0;
    for (int k = 0; k < 5; k++) begin @(negedge sclk); sdata = 1'b0; end
    #1 rst_n = 1'b0;
    #1 check(word == 12'hFFF, "R8 reset mid frame", word, 12'hFFF);
    sdata = 1'b1;
    #20 rst_n = 1'b1;
    idle_bits(20);
    check(word == 12'hFFF, "R8 hunt after reset", word, 12'hFFF);
    measure(12'hFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule